// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the operation and function fields of a 32-bit load/store instruction into the control word for a single-cycle datapath. It recognises seven operations: add, subtract, OR with an immediate, load word, store word, branch when equal and jump. For each one it sets the destination register choice, the second ALU operand source, the writeback source, the register and memory write enables, the branch and jump selects, the immediate extension mode and a 2-bit ALU operation.

The decoder sits between instruction fetch and the datapath. Its outputs are registered, so the control word appears one clock after the fields are presented. Any encoding it does not recognise gives an all-zero control word, so no register, memory or program-counter state changes. Control points that do not matter for an operation are also driven to 0.

Top module: `sc_main_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge.
- R2: The outputs change only at a rising edge and reflect the `opcode` and `funct` values sampled at that edge.
- R3: opcode 000000 with funct 100000 (add) gives dst_rd=1, reg_we=1, alu_op=00 and all other outputs 0.
- R4: opcode 000000 with funct 100010 (subtract) gives dst_rd=1, reg_we=1, alu_op=01 and all other outputs 0.
- R5: opcode 001101 (OR immediate) gives alu_imm=1, reg_we=1, ext_signed=0, alu_op=10 and all other outputs 0.
- R6: opcode 100011 (load word) gives alu_imm=1, load_to_reg=1, reg_we=1, ext_signed=1, alu_op=00 and all other outputs 0.
- R7: opcode 101011 (store word) gives alu_imm=1, mem_we=1, ext_signed=1, alu_op=00 and all other outputs 0.
- R8: opcode 000100 (branch when equal) gives br_sel=1, alu_op=01 and all other outputs 0.
- R9: opcode 000010 (jump) gives jmp_sel=1 and all other outputs 0.
- R10: Any other opcode, and opcode 000000 with a funct other than 100000 or 100010, gives an all-zero control word.
- R11: For every opcode other than 000000 the funct field has no effect on any output.
- R12: At most one of reg_we, mem_we, br_sel and jmp_sel is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction bits 31:26 |
| funct | input | 6 | Instruction bits 5:0 |
| dst_rd | output | 1 | 1 writes the rd field register, 0 the rt field register |
| alu_imm | output | 1 | 1 takes the extended immediate as second ALU operand |
| load_to_reg | output | 1 | 1 writes memory read data back, 0 the ALU result |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| br_sel | output | 1 | Next PC takes the branch target when the compare is equal |
| jmp_sel | output | 1 | Next PC takes the jump target |
| ext_signed | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_op | output | 2 | 00 add, 01 subtract, 10 OR |

## Verification
The assertions assume only that `opcode` and `funct` are known values at every rising edge once reset has been released, and that reset is held high from time zero until the first edge. The stimulus holds reset across the first edges, then changes the inputs only on falling edges and never leaves them undriven, walking all 4096 combinations of the two fields. For each combination the expected control word is worked out from the encodings above, so the unsupported and ignored-field cases are covered as fully as the seven supported operations.

// File: rtl/sc_dec_pkg.sv
package sc_dec_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int AOP_W = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [FN_W-1:0]  FN_ADD    = 6'b100000;
  localparam logic [FN_W-1:0]  FN_SUB    = 6'b100010;

  localparam logic [AOP_W-1:0] AOP_ADD = 2'b00;
  localparam logic [AOP_W-1:0] AOP_SUB = 2'b01;
  localparam logic [AOP_W-1:0] AOP_OR  = 2'b10;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_SUB, K_ORI, K_LOAD, K_STORE, K_BEQ, K_JUMP
  } op_kind_t;

  typedef struct packed {
    logic             dst_rd;
    logic             alu_imm;
    logic             load_to_reg;
    logic             reg_we;
    logic             mem_we;
    logic             br_sel;
    logic             jmp_sel;
    logic             ext_signed;
    logic [AOP_W-1:0] alu_op;
  } ctrl_word_t;

  localparam ctrl_word_t CW_IDLE = '0;
endpackage

// File: rtl/sc_dec_classify.sv
module sc_dec_classify
  import sc_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output op_kind_t         kind
);
  op_kind_t rtype_kind;

  always_comb begin
    case (funct)
      FN_ADD:  rtype_kind = K_ADD;
      FN_SUB:  rtype_kind = K_SUB;
      default: rtype_kind = K_NONE;
    endcase
  end

  always_comb begin
    case (opcode)
      OPC_RTYPE: kind = rtype_kind;
      OPC_ORI:   kind = K_ORI;
      OPC_LOAD:  kind = K_LOAD;
      OPC_STORE: kind = K_STORE;
      OPC_BEQ:   kind = K_BEQ;
      OPC_JUMP:  kind = K_JUMP;
      default:   kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/sc_dec_table.sv
module sc_dec_table
  import sc_dec_pkg::*;
(
  input  op_kind_t   kind,
  output ctrl_word_t cw
);
  always_comb begin
    cw = CW_IDLE;
    case (kind)
      K_ADD: begin
        cw.dst_rd = 1'b1;
        cw.reg_we = 1'b1;
        cw.alu_op = AOP_ADD;
      end
      K_SUB: begin
        cw.dst_rd = 1'b1;
        cw.reg_we = 1'b1;
        cw.alu_op = AOP_SUB;
      end
      K_ORI: begin
        cw.alu_imm = 1'b1;
        cw.reg_we  = 1'b1;
        cw.alu_op  = AOP_OR;
      end
      K_LOAD: begin
        cw.alu_imm     = 1'b1;
        cw.load_to_reg = 1'b1;
        cw.reg_we      = 1'b1;
        cw.ext_signed  = 1'b1;
        cw.alu_op      = AOP_ADD;
      end
      K_STORE: begin
        cw.alu_imm    = 1'b1;
        cw.mem_we     = 1'b1;
        cw.ext_signed = 1'b1;
        cw.alu_op     = AOP_ADD;
      end
      K_BEQ: begin
        cw.br_sel = 1'b1;
        cw.alu_op = AOP_SUB;
      end
      K_JUMP: cw.jmp_sel = 1'b1;
      default: cw = CW_IDLE;
    endcase
  end
endmodule

// File: rtl/sc_main_decoder.sv
module sc_main_decoder
  import sc_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic             dst_rd,
  output logic             alu_imm,
  output logic             load_to_reg,
  output logic             reg_we,
  output logic             mem_we,
  output logic             br_sel,
  output logic             jmp_sel,
  output logic             ext_signed,
  output logic [AOP_W-1:0] alu_op
);
  op_kind_t   kind;
  ctrl_word_t cw_next;
  ctrl_word_t cw_q;

  sc_dec_classify u_classify (
    .opcode (opcode),
    .funct  (funct),
    .kind   (kind)
  );

  sc_dec_table u_table (
    .kind (kind),
    .cw   (cw_next)
  );

  always_ff @(posedge clk) begin
    if (rst) cw_q <= CW_IDLE;
    else     cw_q <= cw_next;
  end

  assign dst_rd      = cw_q.dst_rd;
  assign alu_imm     = cw_q.alu_imm;
  assign load_to_reg = cw_q.load_to_reg;
  assign reg_we      = cw_q.reg_we;
  assign mem_we      = cw_q.mem_we;
  assign br_sel      = cw_q.br_sel;
  assign jmp_sel     = cw_q.jmp_sel;
  assign ext_signed  = cw_q.ext_signed;
  assign alu_op      = cw_q.alu_op;
endmodule

// File: rtl/sc_main_decoder_chk.sv
module sc_main_decoder_chk
  import sc_dec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic [FN_W-1:0]  funct,
  input logic             dst_rd,
  input logic             alu_imm,
  input logic             load_to_reg,
  input logic             reg_we,
  input logic             mem_we,
  input logic             br_sel,
  input logic             jmp_sel,
  input logic             ext_signed,
  input logic [AOP_W-1:0] alu_op
);
  logic [9:0] outs;
  assign outs = {dst_rd, alu_imm, load_to_reg, reg_we, mem_we,
                 br_sel, jmp_sel, ext_signed, alu_op};

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> outs == 10'd0);

  a_r3_add_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OPC_RTYPE && $past(funct) == FN_ADD)
      |-> (dst_rd && reg_we && !mem_we && !alu_imm && alu_op == AOP_ADD));

  a_r7_store_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OPC_STORE)
      |-> (mem_we && !reg_we && alu_imm && ext_signed && alu_op == AOP_ADD));

  a_r8_branch_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OPC_BEQ)
      |-> (br_sel && !reg_we && !mem_we && alu_op == AOP_SUB));

  a_r9_jump_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) == OPC_JUMP) |-> (jmp_sel && !reg_we && !mem_we && !br_sel));

  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opcode) != OPC_RTYPE && $past(opcode) != OPC_ORI &&
     $past(opcode) != OPC_LOAD && $past(opcode) != OPC_STORE &&
     $past(opcode) != OPC_BEQ && $past(opcode) != OPC_JUMP) |-> outs == 10'd0);

  a_r12_one_effect: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_we, mem_we, br_sel, jmp_sel}) <= 1);
endmodule

bind sc_main_decoder sc_main_decoder_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
  .dst_rd(dst_rd), .alu_imm(alu_imm), .load_to_reg(load_to_reg),
  .reg_we(reg_we), .mem_we(mem_we), .br_sel(br_sel), .jmp_sel(jmp_sel),
  .ext_signed(ext_signed), .alu_op(alu_op)
);

// File: tb/sc_main_decoder_test.sv
`timescale 1ns/1ps
module sc_main_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic dst_rd, alu_imm, load_to_reg, reg_we, mem_we, br_sel, jmp_sel, ext_signed;
  logic [1:0] alu_op;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_main_decoder uut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .dst_rd(dst_rd), .alu_imm(alu_imm), .load_to_reg(load_to_reg),
    .reg_we(reg_we), .mem_we(mem_we), .br_sel(br_sel), .jmp_sel(jmp_sel),
    .ext_signed(ext_signed), .alu_op(alu_op)
  );

  // order: dst_rd alu_imm load_to_reg reg_we mem_we br_sel jmp_sel ext_signed alu_op[1:0]
  function automatic logic [9:0] expect_word(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'b000000: begin
        if (fn == 6'b100000)      return 10'b1001000000;
        else if (fn == 6'b100010) return 10'b1001000001;
        else                      return 10'b0;
      end
      6'b001101: return 10'b0101000010;
      6'b100011: return 10'b0111000100;
      6'b101011: return 10'b0100100100;
      6'b000100: return 10'b0000010001;
      6'b000010: return 10'b0000001000;
      default:   return 10'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'b000000: return (fn == 6'b100000) ? "R3" : (fn == 6'b100010) ? "R4" : "R10";
      6'b001101: return (fn == 0) ? "R5" : "R11";
      6'b100011: return (fn == 0) ? "R6" : "R11";
      6'b101011: return (fn == 0) ? "R7" : "R11";
      6'b000100: return (fn == 0) ? "R8" : "R11";
      6'b000010: return (fn == 0) ? "R9" : "R11";
      default:   return "R10";
    endcase
  endfunction

  function automatic logic [9:0] seen();
    return {dst_rd, alu_imm, load_to_reg, reg_we, mem_we, br_sel, jmp_sel, ext_signed, alu_op};
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    opcode = op;
    funct  = fn;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    // R1: reset clears outputs even with a live instruction on the inputs
    @(negedge clk);
    opcode = 6'b100011;
    repeat (3) @(posedge clk);
    #1;
    check("R1", seen(), 10'b0);
    @(negedge clk);
    rst = 1'b0;
    opcode = 6'b000010;
    #1;
    // R2: no change before the edge
    check("R2", seen(), 10'b0);
    @(posedge clk);
    #1;
    check("R2", seen(), expect_word(6'b000010, 6'b0));
    // R2: a change mid-cycle must not propagate before the next edge
    @(negedge clk);
    opcode = 6'b101011;
    #1;
    check("R2", seen(), expect_word(6'b000010, 6'b0));
    // exhaustive sweep R3..R12
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        apply(6'(op), 6'(fn));
        check(tag_of(6'(op), 6'(fn)), seen(), expect_word(6'(op), 6'(fn)));
        if ($countones({reg_we, mem_we, br_sel, jmp_sel}) > 1)
          check("R12", seen(), expect_word(6'(op), 6'(fn)) ^ 10'h3FF);
      end
    end
    // R1: reset again after activity
    @(negedge clk);
    opcode = 6'b000000;
    funct  = 6'b100000;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", seen(), 10'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule